// File: doc/BRIEF.md
# Firmware Image Validator and Loader

This block takes in a microcode image one 32-bit word per cycle, with the most significant byte first, and keeps the words in a local buffer. After the word flagged as last arrives, it checks the image: the tag, the version, the descriptor count, the stated length and the CRC32. Only an image that passes every check is loaded. Loading pulses a split-control strobe if the image asks for it. For each descriptor it then issues one address write that starts auto-incrementing instruction-RAM access, followed by the code words in order. It then writes the non-zero trap entries and finally the enable word of the processor that the descriptor serves.

Image layout, in words. Word 0 holds the tag 0x514546 in bits 31:8 and the version in bits 7:0. Word 1 holds the total image length in bytes. Word 2 holds the descriptor count in bits 7:0. If bits 31:8 of word 2 are zero, the image requests a RAM split. Descriptor d starts at word 3+20·d and holds, in order: a code offset (the word index of the code in the image, 0 for no code), the RAM start offset, a code word count, 16 trap words and an enable word. The final word of the image is the CRC.

Top module: `fw_loader`

## Requirements
- R1: If bits 31:8 of word 0 are not 0x514546, the image is rejected with error code 1.
- R2: If the version in bits 7:0 of word 0 is not 1, the image is rejected with error code 2.
- R3: If the count in bits 7:0 of word 2 is 0 or larger than NUM_RISC, the image is rejected with error code 3.
- R4: The length word must equal 92 + 80·(count−1) + 4·(sum of the descriptor code counts) + 4. It must also equal 4 × the number of words received. Otherwise the image is rejected with error code 4.
- R5: The CRC is the reflected CRC32 (polynomial 0xEDB88320, start value all ones, result inverted). It covers the bytes of every word before the last, most significant byte first. If it differs from the last word, the image is rejected with error code 5.
- R6: When several checks fail, the lowest error code is reported. load_err pulses once and err_code holds the code until the next image is accepted.
- R7: A rejected image causes no RAM, trap, enable or split write.
- R8: split_set pulses once before any other write when bits 31:8 of word 2 are zero, and never when they are non-zero.
- R9: A descriptor with a non-zero code offset produces one address write: ram_addr is the start offset and ram_inc is 1. The address write is followed by the counted code words in image order. A descriptor with code offset 0 produces no RAM writes.
- R10: For descriptor d, each non-zero trap word k is written with trap_cpu=d and trap_idx=k, and zero trap words are skipped. After the traps, one enable write carries the enable word with en_cpu=d.
- R11: load_ok pulses once, with err_code 0, only after the last write of an accepted image.
- R12: Input words offered while busy is high are ignored.
- R13: After reset, busy, err_code and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Image word offered |
| in_word | input | 32 | Image word |
| in_last | input | 1 | Offered word is the CRC word |
| busy | output | 1 | Checking or loading; input ignored |
| ram_addr_wr | output | 1 | RAM address write strobe |
| ram_addr | output | 32 | RAM start offset |
| ram_inc | output | 1 | Auto-increment enable for the address write |
| ram_data_wr | output | 1 | RAM data write strobe |
| ram_data | output | 32 | Code word |
| trap_wr | output | 1 | Trap write strobe |
| trap_cpu | output | CPU_W | Target processor |
| trap_idx | output | 4 | Trap slot |
| trap_val | output | 32 | Trap value |
| en_wr | output | 1 | Enable write strobe |
| en_cpu | output | CPU_W | Target processor |
| en_val | output | 32 | Enable value |
| split_set | output | 1 | RAM split control strobe |
| load_ok | output | 1 | Image loaded pulse |
| load_err | output | 1 | Image rejected pulse |
| err_code | output | 3 | Last result code |

## Verification
The hardest cases to reach are images that fail more than one check. Only the lowest code may appear, and a later check must not mask an earlier one. The vector table builds images with a wrong tag and a wrong CRC together, and with a wrong version and a wrong length together. A separate vector adds one word to an otherwise consistent image, so the length word agrees with the descriptors but not with the number of words received. Words offered while busy are injected right after a valid last word, so that they would restart the receiver if they were not ignored.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam logic [23:0] TAG        = 24'h514546;
  localparam int          HDR_WORDS  = 3;
  localparam int          DESC_WORDS = 20;
  localparam int          TRAP_SLOTS = 16;

  typedef enum logic [3:0] {
    S_RX, S_HDR, S_SUM, S_LEN, S_SPLIT, S_DESC, S_CODE, S_TRAP, S_EN, S_OK, S_ERR
  } fwl_state_e;

  typedef enum logic [2:0] {
    E_OK = 3'd0, E_TAG = 3'd1, E_VER = 3'd2, E_CNT = 3'd3, E_LEN = 3'd4, E_CRC = 3'd5
  } fwl_err_e;

  // reflected CRC32 step over one word, high byte first
  function automatic logic [31:0] crc_word(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 4; b++) begin
      r = r ^ {24'd0, w[31-8*b -: 8]};
      for (int k = 0; k < 8; k++)
        r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] desc_base(input logic [7:0] d);
    return 32'(HDR_WORDS) + 32'(DESC_WORDS) * {24'd0, d};
  endfunction

  function automatic logic [31:0] expected_len(input logic [7:0] cnt, input logic [31:0] sum);
    return 32'(4 * (HDR_WORDS + DESC_WORDS))
         + ({24'd0, cnt} - 32'd1) * 32'(4 * DESC_WORDS)
         + (sum << 2) + 32'd4;
  endfunction
endpackage

// File: rtl/fwl_crc.sv
module fwl_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        step,
  input  logic [31:0] word,
  output logic [31:0] crc_out
);
  import fwl_pkg::*;
  logic [31:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '1;
    else if (clr)  acc <= '1;
    else if (step) acc <= crc_word(acc, word);
  end

  assign crc_out = ~acc;
endmodule

// File: rtl/fwl_store.sv
module fwl_store #(
  parameter int DEPTH = 128,
  parameter int NRD   = 7
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [31:0]          waddr,
  input  logic [31:0]          wdata,
  input  logic [NRD-1:0][31:0] rd_addr,
  output logic [NRD-1:0][31:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  logic [31:0] mem [DEPTH];

  function automatic logic [31:0] fetch(input logic [31:0] a);
    if (a < 32'(DEPTH)) return mem[a[AW-1:0]];
    return 32'd0;
  endfunction

  always_ff @(posedge clk) begin
    if (we && (waddr < 32'(DEPTH))) mem[waddr[AW-1:0]] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = fetch(rd_addr[g]);
  end
endmodule

// File: rtl/fwl_seq.sv
module fwl_seq #(
  parameter int NUM_RISC = 2,
  parameter int CPU_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      hdr0,
  input  logic [31:0]      hdr1,
  input  logic [31:0]      hdr2,
  input  logic [31:0]      nwords,
  input  logic [31:0]      crc_calc,
  input  logic [31:0]      crc_given,
  input  logic [31:0]      f_off,
  input  logic [31:0]      f_cnt,
  input  logic [31:0]      f_fld,
  input  logic [31:0]      f_code,
  output logic [31:0]      a_off,
  output logic [31:0]      a_cnt,
  output logic [31:0]      a_fld,
  output logic [31:0]      a_code,
  output logic             busy,
  output logic             clr,
  output logic             ram_addr_wr,
  output logic [31:0]      ram_addr,
  output logic             ram_inc,
  output logic             ram_data_wr,
  output logic [31:0]      ram_data,
  output logic             trap_wr,
  output logic [CPU_W-1:0] trap_cpu,
  output logic [3:0]       trap_idx,
  output logic [31:0]      trap_val,
  output logic             en_wr,
  output logic [CPU_W-1:0] en_cpu,
  output logic [31:0]      en_val,
  output logic             split_set,
  output logic             load_ok,
  output logic             load_err,
  output logic [2:0]       err_code
);
  import fwl_pkg::*;
  localparam logic [7:0] NUM8 = 8'(NUM_RISC);

  fwl_state_e  st;
  logic [7:0]  d;
  logic [31:0] sum, idx;
  logic [3:0]  t;
  fwl_err_e    err_q;

  logic [7:0]  cnt;
  logic        no_split;
  logic [31:0] base;
  logic        last_desc;

  assign cnt       = hdr2[7:0];
  assign no_split  = (hdr2[31:8] == 24'd0);
  assign base      = desc_base(d);
  assign last_desc = (d == cnt - 8'd1);

  assign a_off  = base;
  assign a_cnt  = base + 32'd2;
  assign a_code = f_off + idx;
  always_comb begin
    case (st)
      S_TRAP:  a_fld = base + 32'd3 + {28'd0, t};
      S_EN:    a_fld = base + 32'(DESC_WORDS - 1);
      default: a_fld = base + 32'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RX; d <= '0; sum <= '0; idx <= '0; t <= '0; err_q <= E_OK;
    end else begin
      case (st)
        S_RX: if (start) st <= S_HDR;
        S_HDR: begin
          if (hdr0[31:8] != TAG)               begin err_q <= E_TAG; st <= S_ERR; end
          else if (hdr0[7:0] != 8'd1)          begin err_q <= E_VER; st <= S_ERR; end
          else if (cnt == 8'd0 || cnt > NUM8)  begin err_q <= E_CNT; st <= S_ERR; end
          else begin d <= '0; sum <= '0; st <= S_SUM; end
        end
        S_SUM: begin
          sum <= sum + f_cnt;
          if (last_desc) st <= S_LEN;
          else           d  <= d + 8'd1;
        end
        S_LEN: begin
          if (expected_len(cnt, sum) != hdr1 || (nwords * 32'd4) != hdr1) begin
            err_q <= E_LEN; st <= S_ERR;
          end else if (crc_calc != crc_given) begin
            err_q <= E_CRC; st <= S_ERR;
          end else begin
            err_q <= E_OK; d <= '0; st <= S_SPLIT;
          end
        end
        S_SPLIT: st <= S_DESC;
        S_DESC: begin
          idx <= '0; t <= '0;
          st  <= (f_off != 32'd0 && f_cnt != 32'd0) ? S_CODE : S_TRAP;
        end
        S_CODE: begin
          if (idx == f_cnt - 32'd1) st <= S_TRAP;
          else                       idx <= idx + 32'd1;
        end
        S_TRAP: begin
          if (t == 4'd15) st <= S_EN;
          else            t  <= t + 4'd1;
        end
        S_EN: begin
          if (last_desc) st <= S_OK;
          else begin d <= d + 8'd1; st <= S_DESC; end
        end
        default: st <= S_RX;
      endcase
    end
  end

  assign busy        = (st != S_RX);
  assign clr         = (st == S_OK) || (st == S_ERR);
  assign split_set   = (st == S_SPLIT) && no_split;
  assign ram_addr_wr = (st == S_DESC) && (f_off != 32'd0);
  assign ram_addr    = f_fld;
  assign ram_inc     = ram_addr_wr;
  assign ram_data_wr = (st == S_CODE);
  assign ram_data    = f_code;
  assign trap_wr     = (st == S_TRAP) && (f_fld != 32'd0);
  assign trap_cpu    = d[CPU_W-1:0];
  assign trap_idx    = t;
  assign trap_val    = f_fld;
  assign en_wr       = (st == S_EN);
  assign en_cpu      = d[CPU_W-1:0];
  assign en_val      = f_fld;
  assign load_ok     = (st == S_OK);
  assign load_err    = (st == S_ERR);
  assign err_code    = err_q;
endmodule

// File: rtl/fw_loader.sv
module fw_loader #(
  parameter int NUM_RISC = 2,
  parameter int DEPTH    = 128,
  localparam int CPU_W   = (NUM_RISC > 1) ? $clog2(NUM_RISC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_word,
  input  logic             in_last,
  output logic             busy,
  output logic             ram_addr_wr,
  output logic [31:0]      ram_addr,
  output logic             ram_inc,
  output logic             ram_data_wr,
  output logic [31:0]      ram_data,
  output logic             trap_wr,
  output logic [CPU_W-1:0] trap_cpu,
  output logic [3:0]       trap_idx,
  output logic [31:0]      trap_val,
  output logic             en_wr,
  output logic [CPU_W-1:0] en_cpu,
  output logic [31:0]      en_val,
  output logic             split_set,
  output logic             load_ok,
  output logic             load_err,
  output logic [2:0]       err_code
);
  localparam int NRD = 7;

  logic                 accept, start, clr;
  logic [31:0]          nwords, crc_given, crc_calc;
  logic [NRD-1:0][31:0] rd_addr, rd_data;
  logic [31:0]          a_off, a_cnt, a_fld, a_code;

  assign accept = in_valid && !busy;
  assign start  = accept && in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nwords <= '0; crc_given <= '0;
    end else begin
      if (clr)         nwords <= '0;
      else if (accept) nwords <= nwords + 32'd1;
      if (start) crc_given <= in_word;
    end
  end

  fwl_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(accept && !in_last),
    .word(in_word), .crc_out(crc_calc)
  );

  assign rd_addr[0] = 32'd0;
  assign rd_addr[1] = 32'd1;
  assign rd_addr[2] = 32'd2;
  assign rd_addr[3] = a_off;
  assign rd_addr[4] = a_cnt;
  assign rd_addr[5] = a_fld;
  assign rd_addr[6] = a_code;

  fwl_store #(.DEPTH(DEPTH), .NRD(NRD)) u_store (
    .clk(clk), .we(accept), .waddr(nwords), .wdata(in_word),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  fwl_seq #(.NUM_RISC(NUM_RISC), .CPU_W(CPU_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .hdr0(rd_data[0]), .hdr1(rd_data[1]), .hdr2(rd_data[2]),
    .nwords(nwords), .crc_calc(crc_calc), .crc_given(crc_given),
    .f_off(rd_data[3]), .f_cnt(rd_data[4]), .f_fld(rd_data[5]), .f_code(rd_data[6]),
    .a_off(a_off), .a_cnt(a_cnt), .a_fld(a_fld), .a_code(a_code),
    .busy(busy), .clr(clr),
    .ram_addr_wr(ram_addr_wr), .ram_addr(ram_addr), .ram_inc(ram_inc),
    .ram_data_wr(ram_data_wr), .ram_data(ram_data),
    .trap_wr(trap_wr), .trap_cpu(trap_cpu), .trap_idx(trap_idx), .trap_val(trap_val),
    .en_wr(en_wr), .en_cpu(en_cpu), .en_val(en_val),
    .split_set(split_set), .load_ok(load_ok), .load_err(load_err), .err_code(err_code)
  );
endmodule

// File: rtl/fw_loader_chk.sv
module fw_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        busy,
  input logic [31:0] nwords,
  input logic        ram_addr_wr,
  input logic        ram_data_wr,
  input logic        trap_wr,
  input logic [31:0] trap_val,
  input logic        en_wr,
  input logic        split_set,
  input logic        load_ok,
  input logic        load_err,
  input logic [2:0]  err_code
);
  logic any_wr, rejected, addr_seen;
  assign any_wr = ram_addr_wr || ram_data_wr || trap_wr || en_wr || split_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rejected <= 1'b0; addr_seen <= 1'b0;
    end else begin
      if (load_err)                 rejected <= 1'b1;
      else if (in_valid && !busy)   rejected <= 1'b0;
      if (load_ok || load_err)      addr_seen <= 1'b0;
      else if (ram_addr_wr)         addr_seen <= 1'b1;
    end
  end

  p_err_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> (err_code >= 3'd1 && err_code <= 3'd5));
  p_no_write_after_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |-> !rejected);
  p_data_after_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_data_wr |-> addr_seen);
  p_trap_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_wr |-> (trap_val != 32'd0));
  p_ok_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |-> (err_code == 3'd0 && !load_err));
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_addr_wr, ram_data_wr, trap_wr, en_wr, split_set, load_ok, load_err}));
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && !load_ok && !load_err) |=> (nwords == $past(nwords)));
endmodule

bind fw_loader fw_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy), .nwords(nwords),
  .ram_addr_wr(ram_addr_wr), .ram_data_wr(ram_data_wr), .trap_wr(trap_wr),
  .trap_val(trap_val), .en_wr(en_wr), .split_set(split_set),
  .load_ok(load_ok), .load_err(load_err), .err_code(err_code)
);

// File: tb/sim_fw_loader.sv
`timescale 1ns/1ps
module sim_fw_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_word = '0;
  logic busy, ram_addr_wr, ram_inc, ram_data_wr, trap_wr, en_wr, split_set, load_ok, load_err;
  logic [31:0] ram_addr, ram_data, trap_val, en_val;
  logic [0:0] trap_cpu, en_cpu;
  logic [3:0] trap_idx;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  fw_loader u0 (.*);

  int errs = 0, checks = 0;
  logic [31:0] img [0:127];
  int nimg;
  logic [63:0] ev [0:63];
  logic [63:0] xp [0:63];
  int nev = 0, nxp = 0, ok_seen = 0, err_seen = 0;
  bit done_flag = 0;

  // kind[7:4], expected code[3:0]
  localparam logic [7:0] VEC [0:11] = '{
    8'h00, 8'h11, 8'h22, 8'h33, 8'h43, 8'h54, 8'h65, 8'h71, 8'h82, 8'h90, 8'hA0, 8'hB4 };

  task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int sh = 24; sh >= 0; sh -= 8) begin
        logic [7:0] by = img[i][sh +: 8];
        for (int k = 0; k < 8; k++) begin
          logic fb = c[0] ^ by[k];
          c = {1'b0, c[31:1]};
          if (fb) c = c ^ 32'hEDB88320;
        end
      end
    return ~c;
  endfunction

  function automatic string req_of(input int kind);
    case (kind)
      1: return "R1"; 2: return "R2"; 3, 4: return "R3"; 5, 11: return "R4";
      6: return "R5"; 7, 8: return "R6"; 9: return "R8"; default: return "R11";
    endcase
  endfunction

  task automatic push_xp(input logic [63:0] e);
    xp[nxp] = e; nxp++;
  endtask

  task automatic build(input int kind);
    int nd, cat;
    logic [7:0] cnt;
    nd  = (kind == 10) ? 1 : 2;
    cnt = (kind == 3) ? 8'd0 : (kind == 4) ? 8'd3 : 8'(nd);
    cat = 3 + 20 * nd;
    for (int i = 0; i < 128; i++) img[i] = '0;
    img[0] = {((kind == 1 || kind == 7) ? 24'h514547 : 24'h514546),
              ((kind == 2 || kind == 8) ? 8'd2 : 8'd1)};
    img[2] = {((kind == 9) ? 24'h000001 : 24'h0), cnt};
    img[3] = 32'(cat); img[4] = 32'h100; img[5] = 32'd3;
    img[3+3+2] = 32'hA2; img[3+3+7] = 32'h77; img[3+19] = 32'h8001;
    if (nd == 2) begin
      img[23] = 32'd0; img[24] = 32'h55; img[25] = 32'd0;
      img[23+3+0] = 32'h10; img[23+3+15] = 32'hFF; img[23+19] = 32'h8002;
    end
    for (int i = 0; i < 3; i++) img[cat+i] = 32'hC0DE0001 + 32'(i);
    nimg = cat + 3;
    img[1] = 32'(4 * (nimg + 1));
    if (kind == 5) img[1] = img[1] + 32'd4;
    if (kind == 8) img[1] = img[1] + 32'd8;
    if (kind == 11) begin img[nimg] = 32'hDEADBEEF; nimg++; end
    img[nimg] = crc_ref(nimg) ^ ((kind == 6 || kind == 7) ? 32'd1 : 32'd0);
    nimg++;
    nxp = 0;
    if (kind == 0 || kind == 9 || kind == 10) begin
      if (kind != 9) push_xp({8'd5, 24'd0, 32'd0});
      push_xp({8'd1, 16'd0, 8'd1, 32'h100});
      for (int i = 0; i < 3; i++) push_xp({8'd2, 24'd0, 32'hC0DE0001 + 32'(i)});
      push_xp({8'd3, 8'd0, 8'd2, 8'd0, 32'hA2});
      push_xp({8'd3, 8'd0, 8'd7, 8'd0, 32'h77});
      push_xp({8'd4, 24'd0, 32'h8001});
      if (nd == 2) begin
        push_xp({8'd3, 8'd1, 8'd0, 8'd0, 32'h10});
        push_xp({8'd3, 8'd1, 8'd15, 8'd0, 32'hFF});
        push_xp({8'd4, 8'd1, 16'd0, 32'h8002});
      end
    end
  endtask

  task automatic send(input int junk);
    for (int i = 0; i < nimg; i++) begin
      @(negedge clk); in_valid = 1'b1; in_word = img[i]; in_last = (i == nimg - 1);
    end
    for (int j = 0; j < junk; j++) begin
      @(negedge clk); in_valid = 1'b1; in_word = 32'h12345678 + 32'(j); in_last = 1'b1;
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run(input int kind, input int exp_code, input int junk);
    string rq;
    int w;
    rq = req_of(kind);
    nev = 0; ok_seen = 0; err_seen = 0;
    send(junk);
    w = 0;
    while (ok_seen + err_seen == 0 && w < 3000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk(w < 3000, {rq, " result arrived"}, 64'(w), 64'd0);
    if (exp_code == 0) begin
      chk(ok_seen == 1 && err_seen == 0, {rq, " R11 load_ok once"}, 64'(ok_seen), 64'd1);
    end else begin
      chk(err_seen == 1 && ok_seen == 0, {rq, " R6 load_err once"}, 64'(err_seen), 64'd1);
    end
    chk(err_code == 3'(exp_code), {rq, " err_code"}, 64'(err_code), 64'(exp_code));
    chk(nev == nxp, {rq, " R7 R9 R10 write count"}, 64'(nev), 64'(nxp));
    for (int i = 0; i < nxp && i < nev; i++)
      chk(ev[i] == xp[i], {rq, " R9 R10 write order"}, ev[i], xp[i]);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (split_set)   begin ev[nev & 63] = {8'd5, 24'd0, 32'd0}; nev++; end
      if (ram_addr_wr) begin ev[nev & 63] = {8'd1, 16'd0, 7'd0, ram_inc, ram_addr}; nev++; end
      if (ram_data_wr) begin ev[nev & 63] = {8'd2, 24'd0, ram_data}; nev++; end
      if (trap_wr)     begin ev[nev & 63] = {8'd3, 7'd0, trap_cpu, 4'd0, trap_idx, 8'd0, trap_val}; nev++; end
      if (en_wr)       begin ev[nev & 63] = {8'd4, 7'd0, en_cpu, 16'd0, en_val}; nev++; end
      if (load_ok)     ok_seen++;
      if (load_err)    err_seen++;
    end
  end

  initial begin
    #1500000;
    if (!done_flag) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!busy && err_code == 3'd0, "R13 reset busy/err_code", {busy, err_code}, 0);
    chk(!(ram_addr_wr | ram_data_wr | trap_wr | en_wr | split_set | load_ok | load_err),
        "R13 reset strobes", 64'(ram_addr_wr | trap_wr | en_wr), 0);
    for (int v = 0; v < 12; v++) begin
      build(int'(VEC[v][7:4]));
      run(int'(VEC[v][7:4]), int'(VEC[v][3:0]), 0);
    end
    // R12: words offered right after the last word while busy
    build(0);
    run(0, 0, 6);
    nev = 0; ok_seen = 0; err_seen = 0;
    repeat (60) @(negedge clk);
    chk(ok_seen == 0 && err_seen == 0 && nev == 0 && !busy, "R12 busy input ignored",
        64'(ok_seen + err_seen + nev), 0);
    // R6: error code held, then cleared by an accepted image (R11)
    build(6); run(6, 5, 0);
    repeat (10) @(negedge clk);
    chk(err_code == 3'd5, "R6 err_code held", 64'(err_code), 5);
    build(0); run(0, 0, 0);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule